// File: doc/BRIEF.md
# Memory Response Controller with Owner Intervention

This block is the memory side of a read or store miss on a snooping split-transaction bus. When a miss request is seen, it starts fetching the cache line from storage straight away, in parallel with the snoop of the other caches. It does not know yet whether memory or a cache will supply the data. A cache that owns the line in modified state holds the inhibit line high. That keeps memory off the data bus until the owner has won the bus. The owner then drops inhibit and raises the modified line.

On the first cycle in which inhibit is low, the controller samples the modified line. If modified is clear, it asks for the data bus once its fetch is complete and sends the line in consecutive beats. If modified is set, it cancels its response. On a read miss it then captures the owner's beats from the data bus and issues one write-back of the whole line. On a store miss the owner's data is not written back. One miss is handled at a time. The block stays busy until its own fetch has returned, even if the response was cancelled, so that a late fetch completion can never be mistaken for the next request's data.

Top module: `memresp_ctrl`

## Requirements
- R1: In a cycle where the block is idle and `req_valid` is high, `fetch_start` is high in that same cycle and `fetch_addr` equals `req_addr`.
- R2: While a miss is in progress, `req_valid` is ignored: `fetch_start` stays low, and the request in progress is not disturbed.
- R3: `dbus_req` stays low in every cycle up to and including the first cycle in which `inhibit_in` is low after the request. This holds even if the fetch has completed.
- R4: `modified_in` is sampled only in the first cycle with `inhibit_in` low. If it is clear there, `dbus_req` rises in the cycle after the later of two events: that sampling cycle, and the cycle in which `fetch_done` pulsed.
- R5: `dbus_req` stays high until the cycle in which `dbus_gnt` is high. Over the next four cycles `dout_valid` is high, and beat k of `dout_data` is bits [64k+63:64k] of `fetch_line` as presented with `fetch_done`. The block is idle in the cycle after the last beat.
- R6: If `modified_in` is high when sampled, neither `dbus_req` nor `dout_valid` is raised for that miss.
- R7: For a read miss (`req_is_store` = 0) with `modified_in` sampled high, the block captures the first four cycles with `bus_valid` high, starting in the cycle after the sampling cycle; gaps between beats are allowed. In the cycle after the fourth beat, `wb_valid` is high for one cycle. `wb_line` then holds beat k in bits [64k+63:64k], and `wb_addr` is the request address.
- R8: For a store miss (`req_is_store` = 1) with `modified_in` sampled high, `wb_valid` never rises for that miss.
- R9: After a cancelled response, the block becomes idle only in the cycle after both conditions are met: its own `fetch_done` has arrived, and any write-back capture has ended.
- R10: During and right after reset, `fetch_start`, `dbus_req`, `dout_valid` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request seen on the address bus |
| req_is_store | input | 1 | 1 = store miss, 0 = read miss |
| req_addr | input | ADDR_W | Line address of the request |
| fetch_start | output | 1 | Starts the line fetch from storage |
| fetch_addr | output | ADDR_W | Address for the fetch |
| fetch_done | input | 1 | One-cycle pulse: fetched line is valid |
| fetch_line | input | BEAT_W*BEATS | Fetched line, valid with fetch_done |
| inhibit_in | input | 1 | Wired inhibit line from the snooping caches |
| modified_in | input | 1 | Wired modified line from the owning cache |
| dbus_req | output | 1 | Data bus request |
| dbus_gnt | input | 1 | Data bus grant |
| dout_valid | output | 1 | Memory drives a data beat |
| dout_data | output | BEAT_W | Data beat from memory |
| bus_valid | input | 1 | A beat is on the data bus (from the owner) |
| bus_data | input | BEAT_W | Data bus beat seen by memory |
| wb_valid | output | 1 | One-cycle write-back of a captured line |
| wb_addr | output | ADDR_W | Write-back address |
| wb_line | output | BEAT_W*BEATS | Captured line for write-back |

## Verification
If the resolution state is wrong, it shows at the ports within one cycle. `dbus_req` would rise under inhibit or after a modified sample, or it would fail to rise the cycle after fetch and clean resolution both hold. A stuck or miscounted beat counter shows within four cycles of the grant or of capture start: either as a wrong beat on `dout_data`, or as `wb_valid` in the wrong cycle or with misplaced lanes in `wb_line`. A lost fetch-done flag after a cancel shows as a `fetch_start` that is missing or early when the next request is accepted.

// File: rtl/memresp_pkg.sv
package memresp_pkg;

   typedef enum logic [2:0] {
      MR_IDLE  = 3'd0,
      MR_SNOOP = 3'd1,
      MR_CLEAN = 3'd2,
      MR_SEND  = 3'd3,
      MR_CAPT  = 3'd4,
      MR_DRAIN = 3'd5
   } mr_state_e;

endpackage

// File: rtl/memresp_seq.sv
module memresp_seq
   import memresp_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_is_store,
   input  logic fetch_done,
   input  logic inhibit_in,
   input  logic modified_in,
   input  logic dbus_gnt,
   input  logic send_last,
   input  logic cap_last,
   output logic fetch_start,
   output logic dbus_req,
   output logic sending,
   output logic capturing,
   output logic load_line
);

   mr_state_e st_q, st_d;
   logic      store_q;
   logic      fetched_q;
   logic      fetch_in_hand;

   assign fetch_in_hand = fetched_q | fetch_done;
   assign fetch_start   = (st_q == MR_IDLE) && req_valid;
   assign dbus_req      = (st_q == MR_CLEAN) && fetched_q;
   assign sending       = (st_q == MR_SEND);
   assign capturing     = (st_q == MR_CAPT);
   assign load_line     = (st_q != MR_IDLE) && fetch_done;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         MR_IDLE:  if (req_valid) st_d = MR_SNOOP;
         MR_SNOOP: begin
            if (!inhibit_in) begin
               if (!modified_in)     st_d = MR_CLEAN;
               else if (!store_q)    st_d = MR_CAPT;
               else if (fetch_in_hand) st_d = MR_IDLE;
               else                  st_d = MR_DRAIN;
            end
         end
         MR_CLEAN: if (dbus_req && dbus_gnt) st_d = MR_SEND;
         MR_SEND:  if (send_last) st_d = MR_IDLE;
         MR_CAPT:  if (cap_last) st_d = fetch_in_hand ? MR_IDLE : MR_DRAIN;
         MR_DRAIN: if (fetch_done) st_d = MR_IDLE;
         default:  st_d = MR_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= MR_IDLE;
         store_q   <= 1'b0;
         fetched_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (fetch_start) begin
            store_q   <= req_is_store;
            fetched_q <= 1'b0;
         end else if (load_line) begin
            fetched_q <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/memresp_tx.sv
module memresp_tx #(
   parameter int BEAT_W = 64,
   parameter int BEATS  = 4,
   localparam int LINE_W = BEAT_W * BEATS,
   localparam int CNT_W  = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_line,
   input  logic [LINE_W-1:0] fetch_line,
   input  logic              sending,
   output logic              send_last,
   output logic              dout_valid,
   output logic [BEAT_W-1:0] dout_data
);

   logic [LINE_W-1:0] line_q;
   logic [CNT_W-1:0]  beat_q;

   assign dout_valid = sending;
   assign send_last  = sending && (beat_q == CNT_W'(BEATS - 1));
   assign dout_data  = sending ? line_q[beat_q * BEAT_W +: BEAT_W] : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         line_q <= '0;
         beat_q <= '0;
      end else begin
         if (load_line) line_q <= fetch_line;
         if (send_last)    beat_q <= '0;
         else if (sending) beat_q <= beat_q + 1'b1;
      end
   end

endmodule

// File: rtl/memresp_wb.sv
module memresp_wb #(
   parameter int ADDR_W = 32,
   parameter int BEAT_W = 64,
   parameter int BEATS  = 4,
   localparam int LINE_W = BEAT_W * BEATS,
   localparam int CNT_W  = $clog2(BEATS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_start,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              capturing,
   input  logic              bus_valid,
   input  logic [BEAT_W-1:0] bus_data,
   output logic              cap_last,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [LINE_W-1:0] wb_line
);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              take;

   assign take     = capturing && bus_valid;
   assign cap_last = take && (cnt_q == CNT_W'(BEATS - 1));

   for (genvar k = 0; k < BEATS; k++) begin : g_lane
      logic [BEAT_W-1:0] lane_q;
      always_ff @(posedge clk) begin
         if (!rst_n)                             lane_q <= '0;
         else if (take && cnt_q == CNT_W'(k))    lane_q <= bus_data;
      end
      assign wb_line[k*BEAT_W +: BEAT_W] = lane_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         addr_q   <= '0;
         wb_addr  <= '0;
         wb_valid <= 1'b0;
      end else begin
         wb_valid <= cap_last;
         if (fetch_start) addr_q <= req_addr;
         if (cap_last) begin
            cnt_q   <= '0;
            wb_addr <= addr_q;
         end else if (take) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

endmodule

// File: rtl/memresp_ctrl.sv
module memresp_ctrl #(
   parameter int ADDR_W = 32,
   parameter int BEAT_W = 64,
   parameter int BEATS  = 4,
   localparam int LINE_W = BEAT_W * BEATS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_is_store,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              fetch_start,
   output logic [ADDR_W-1:0] fetch_addr,
   input  logic              fetch_done,
   input  logic [LINE_W-1:0] fetch_line,
   input  logic              inhibit_in,
   input  logic              modified_in,
   output logic              dbus_req,
   input  logic              dbus_gnt,
   output logic              dout_valid,
   output logic [BEAT_W-1:0] dout_data,
   input  logic              bus_valid,
   input  logic [BEAT_W-1:0] bus_data,
   output logic              wb_valid,
   output logic [ADDR_W-1:0] wb_addr,
   output logic [LINE_W-1:0] wb_line
);

   if (BEATS < 2 || (BEATS & (BEATS - 1)) != 0) begin : g_bad_beats
      $error("memresp_ctrl: BEATS must be a power of two of at least 2");
   end
   if (BEAT_W < 8 || ADDR_W < 1) begin : g_bad_width
      $error("memresp_ctrl: BEAT_W must be at least 8 and ADDR_W at least 1");
   end

   logic sending, capturing, load_line, send_last, cap_last;

   assign fetch_addr = req_addr;

   memresp_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_is_store (req_is_store),
      .fetch_done   (fetch_done),
      .inhibit_in   (inhibit_in),
      .modified_in  (modified_in),
      .dbus_gnt     (dbus_gnt),
      .send_last    (send_last),
      .cap_last     (cap_last),
      .fetch_start  (fetch_start),
      .dbus_req     (dbus_req),
      .sending      (sending),
      .capturing    (capturing),
      .load_line    (load_line)
   );

   memresp_tx #(.BEAT_W(BEAT_W), .BEATS(BEATS)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_line  (load_line),
      .fetch_line (fetch_line),
      .sending    (sending),
      .send_last  (send_last),
      .dout_valid (dout_valid),
      .dout_data  (dout_data)
   );

   memresp_wb #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W), .BEATS(BEATS)) u_wb (
      .clk         (clk),
      .rst_n       (rst_n),
      .fetch_start (fetch_start),
      .req_addr    (req_addr),
      .capturing   (capturing),
      .bus_valid   (bus_valid),
      .bus_data    (bus_data),
      .cap_last    (cap_last),
      .wb_valid    (wb_valid),
      .wb_addr     (wb_addr),
      .wb_line     (wb_line)
   );

endmodule

// File: rtl/memresp_ctrl_chk.sv
module memresp_ctrl_chk (
   input logic clk,
   input logic rst_n,
   input logic fetch_start,
   input logic dbus_req,
   input logic dbus_gnt,
   input logic dout_valid,
   input logic wb_valid,
   input logic capturing
);

   AST_START_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start |=> !fetch_start); // R2

   AST_NO_REQ_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_start |=> !dbus_req); // R3

   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_req && !dbus_gnt) |=> dbus_req); // R5

   AST_DOUT_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dout_valid) |-> $past(dbus_req && dbus_gnt)); // R5

   AST_ONE_ACTOR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({dbus_req, dout_valid, capturing})); // R6

   AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |=> !wb_valid); // R7

endmodule

bind memresp_ctrl memresp_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fetch_start (fetch_start),
   .dbus_req    (dbus_req),
   .dbus_gnt    (dbus_gnt),
   .dout_valid  (dout_valid),
   .wb_valid    (wb_valid),
   .capturing   (capturing)
);

// File: tb/memresp_ctrl_test.sv
`timescale 1ns/1ps
module memresp_ctrl_test;

   localparam int AW = 32;
   localparam int BW = 64;
   localparam int NB = 4;
   localparam int LW = BW * NB;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_is_store = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic fetch_start;
   logic [AW-1:0] fetch_addr;
   logic fetch_done = 1'b0;
   logic [LW-1:0] fetch_line = '0;
   logic inhibit_in = 1'b0, modified_in = 1'b0;
   logic dbus_req;
   logic dbus_gnt = 1'b0;
   logic dout_valid;
   logic [BW-1:0] dout_data;
   logic bus_valid = 1'b0;
   logic [BW-1:0] bus_data = '0;
   logic wb_valid;
   logic [AW-1:0] wb_addr;
   logic [LW-1:0] wb_line;

   int checks = 0, failures = 0, cyc = 0;
   int wb_exp_cyc = -1;
   logic [AW-1:0] wb_exp_addr;
   logic [LW-1:0] wb_exp_line;

   always #2 clk = ~clk;

   memresp_ctrl uut (.*);

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic logic [LW-1:0] rand_line();
      logic [LW-1:0] v;
      for (int i = 0; i < LW / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [LW-1:0] act,
                      input logic [LW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
      end
   endtask

   task automatic chk_wb();
      bit e = (cyc == wb_exp_cyc);
      chk(wb_valid == e, "R7/R8 wb_valid", LW'(wb_valid), LW'(e));
      if (e && wb_valid) begin
         chk(wb_line == wb_exp_line, "R7 wb_line", wb_line, wb_exp_line);
         chk(wb_addr == wb_exp_addr, "R7 wb_addr", LW'(wb_addr), LW'(wb_exp_addr));
      end
   endtask

   task automatic tick();
      @(negedge clk);
      cyc++;
   endtask

   // inh: cycles inhibit stays high; flat: cycle of fetch_done (>=1);
   // glat: grant delay after dbus_req is expected to rise
   task automatic run_txn(input bit store, input int inh, input int flat,
                          input bit md, input int glat);
      logic [AW-1:0] a = $urandom;
      logic [LW-1:0] line = rand_line();
      int c_r = inh + 1;
      int exp_req = imax(c_r, flat) + 1;
      int g = exp_req + glat;
      int idle_c = 0;
      int bi = 0;
      int b4 = 0;
      logic [LW-1:0] cap = '0;
      if (!md) idle_c = g + 5;
      else if (store) idle_c = imax(c_r, flat) + 1;
      // request cycle
      tick();
      req_valid = 1'b1; req_addr = a; req_is_store = store;
      fetch_done = 1'b0; dbus_gnt = 1'b0; bus_valid = 1'b0;
      inhibit_in = $urandom; modified_in = $urandom;
      #1;
      chk(fetch_start == 1'b1, "R1 fetch_start", LW'(fetch_start), LW'(1));
      chk(fetch_addr == a, "R1 fetch_addr", LW'(fetch_addr), LW'(a));
      chk(dbus_req == 1'b0 && dout_valid == 1'b0, "R3 quiet at start",
          LW'({dbus_req, dout_valid}), LW'(0));
      chk_wb();
      for (int c = 1; ; c++) begin
         bit er, ev;
         tick();
         req_valid   = $urandom;
         req_addr    = $urandom;
         req_is_store = $urandom;
         inhibit_in  = (c < c_r) ? 1'b1 : ((c == c_r) ? 1'b0 : 1'($urandom));
         modified_in = (c == c_r) ? md : 1'($urandom);
         fetch_done  = (c == flat);
         fetch_line  = (c == flat) ? line : rand_line();
         if (!md) dbus_gnt = (c == g) ? 1'b1 : ((c < exp_req) ? 1'($urandom) : 1'b0);
         else     dbus_gnt = $urandom;
         bus_data  = {$urandom, $urandom};
         if (md && !store && c > c_r && bi < NB) begin
            bus_valid = ($urandom % 3) != 0;
            if (bus_valid) begin
               cap[bi*BW +: BW] = bus_data;
               bi++;
               if (bi == NB) begin
                  b4 = c;
                  idle_c = imax(b4, flat) + 1;
                  wb_exp_cyc  = cyc + 1;
                  wb_exp_line = cap;
                  wb_exp_addr = a;
               end
            end
         end else begin
            bus_valid = $urandom;
         end
         #1;
         chk(fetch_start == 1'b0, "R2/R9 busy ignores request", LW'(fetch_start), LW'(0));
         er = !md && c >= exp_req && c <= g;
         chk(dbus_req == er, md ? "R6 no request on modified" : "R3/R4 dbus_req timing",
             LW'(dbus_req), LW'(er));
         ev = !md && c > g && c <= g + NB;
         chk(dout_valid == ev, md ? "R6 no data on modified" : "R5 dout_valid",
             LW'(dout_valid), LW'(ev));
         if (ev && dout_valid)
            chk(dout_data == line[(c - g - 1)*BW +: BW], "R5 beat data",
                LW'(dout_data), LW'(line[(c - g - 1)*BW +: BW]));
         chk_wb();
         if (idle_c != 0 && c == idle_c - 1) break;
         if (c > 500) break;
      end
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) begin
         @(negedge clk);
         #1;
         chk({fetch_start, dbus_req, dout_valid, wb_valid} == 4'b0, "R10 reset outputs",
             LW'({fetch_start, dbus_req, dout_valid, wb_valid}), LW'(0));
      end
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk({dbus_req, dout_valid, wb_valid} == 3'b0, "R10 idle after reset",
          LW'({dbus_req, dout_valid, wb_valid}), LW'(0));
      // directed corners
      run_txn(1'b0, 0, 1, 1'b0, 0);   // R4: no owner, fetch at once, immediate grant
      run_txn(1'b0, 5, 2, 1'b0, 3);   // R3: fetch done long before inhibit drops
      run_txn(1'b1, 2, 3, 1'b0, 1);   // R4: fetch done in the resolution cycle
      run_txn(1'b0, 1, 9, 1'b0, 0);   // R4: fetch after resolution
      run_txn(1'b0, 3, 2, 1'b1, 0);   // R7: read miss, owner supplies
      run_txn(1'b0, 1, 25, 1'b1, 0);  // R9: capture ends before fetch
      run_txn(1'b1, 2, 12, 1'b1, 0);  // R8/R9: store abort waits for fetch
      run_txn(1'b1, 4, 1, 1'b1, 0);   // R8: store abort, fetch already in
      // random mix
      for (int n = 0; n < 300; n++)
         run_txn(1'($urandom), $urandom % 6, 1 + $urandom % 10,
                 1'($urandom), $urandom % 4);
      tick();
      req_valid = 1'b0;
      #1;
      chk_wb();
      tick();
      #1;
      chk_wb();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule